// File: doc/BRIEF.md
# Shared Channel Access Arbiter

This block decides who may drive a single auxiliary-channel engine: host software or an embedded microcontroller. A two-bit status output always shows the current owner. The host asks for the channel with a one-cycle request pulse. The microcontroller asks by holding a request level. Either owner gives the channel back by pulsing its own release input.

Before the host is granted the channel, the engine must be enabled. If the engine is already enabled, the host claim is evaluated on the next cycle. If the engine is disabled, the block raises enable and reset together. It then polls the engine's reset-done feedback at a fixed poll interval and waits for it to go high. Next it drops reset and waits for reset-done to go low. Only after that does it try the claim. The claim succeeds only if the channel is still free at that moment.

If either phase of the handshake uses up its poll budget, the block raises a timeout flag. It then drops enable and reset and grants nothing.

Top module: `chan_owner_arbiter`

## Requirements
- R1: `owner_status` reads 0 when the channel is free, 1 when the host owns it and 2 when the microcontroller owns it. It reads 0 after reset, and the value 3 never appears.
- R2: A host request made while the status reads 2 produces a `host_refuse` pulse on the next cycle, leaves the status at 2 and starts no enable sequence.
- R3: A host request made while the channel is free and `eng_en` is 0 drives `eng_en` and `eng_rst` both to 1 on the following cycle. `eng_rst` is never 1 while `eng_en` is 0.
- R4: Reset-done is sampled once every POLL_CYCLES cycles. `eng_rst` drops only after a poll has seen reset-done high. The sequence completes at the first later poll that sees reset-done low. With feedback that follows `eng_rst` after one cycle, the grant appears 2*POLL_CYCLES+1 cycles after the request edge.
- R5: If reset-done is not seen high within POLL_LIMIT polls, `timeout_err` rises POLL_LIMIT*POLL_CYCLES cycles after the request edge. If the seen-high phase passes but the seen-low phase runs out, it rises (POLL_LIMIT+1)*POLL_CYCLES cycles after the request edge. In both cases `eng_en` and `eng_rst` go to 0 and no grant is given. The next accepted host request clears `timeout_err`.
- R6: The host claim is made only after the engine is enabled. The claim is granted only if the status is free and the microcontroller is not requesting at that moment; otherwise it is refused. `host_grant` is a one-cycle pulse and coincides with status 1. With the engine already enabled, the grant follows the request edge by one cycle.
- R7: A release pulse frees the channel on the next cycle only when it comes from the current owner. A release from the side that does not own the channel leaves the status unchanged.
- R8: The microcontroller takes a free channel on the cycle after its request is seen. When both sides contend for a free channel, the microcontroller wins and the host is refused. A microcontroller request made while the host owns the channel waits until the host releases it.
- R9: A host request made while the host already owns the channel produces a `host_grant` pulse on the next cycle and leaves the status at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request pulse |
| host_done | input | 1 | Host release pulse |
| mcu_req | input | 1 | Microcontroller request level |
| mcu_done | input | 1 | Microcontroller release pulse |
| eng_rst_done | input | 1 | Reset-done feedback from the engine |
| eng_en | output | 1 | Engine enable |
| eng_rst | output | 1 | Engine reset |
| owner_status | output | 2 | Owner code: 0 free, 1 host, 2 microcontroller |
| host_grant | output | 1 | One-cycle pulse: host claim accepted |
| host_refuse | output | 1 | One-cycle pulse: host claim refused |
| timeout_err | output | 1 | Sticky flag: the enable handshake ran out of polls |

## Verification
The bench builds the block with POLL_CYCLES=2 and POLL_LIMIT=3. At these values both timeout windows close within a handful of cycles, so each one can be reached on its own. A small engine model in the bench makes reset-done follow reset, stick low or stick high. This selects the full handshake, a timeout in the first phase or a timeout in the second phase. The exact arrival cycle of every grant, refusal and timeout is then predicted arithmetically from the two parameters and compared against the outputs.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_MCU  = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RST_ON,
    SQ_RST_OFF
  } seq_e;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_ENABLE,
    HS_CLAIM
  } host_e;

  // Host claim succeeds only on a free channel with no contending microcontroller.
  function automatic logic host_may_claim(owner_e own, logic mcu_wants);
    return (own == OWN_NONE) && !mcu_wants;
  endfunction

  // Cycles a single handshake phase may spend before timing out.
  function automatic int phase_window(int poll_cycles, int poll_limit);
    return poll_cycles * poll_limit;
  endfunction

endpackage

// File: rtl/chan_arb_poll_timer.sv
module chan_arb_poll_timer #(
  parameter int POLL_CYCLES = 100,
  parameter int POLL_LIMIT  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick,
  output logic last_poll
);
  localparam int SUB_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] polls_q;

  assign tick      = run && (sub_q == SUB_W'(POLL_CYCLES - 1));
  assign last_poll = (polls_q == CNT_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) begin
      sub_q   <= '0;
      polls_q <= '0;
    end else if (tick) begin
      sub_q <= '0;
      if (!last_poll) polls_q <= polls_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  // The poll counter never passes the final poll index.
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= CNT_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/chan_arb_enable_seq.sv
module chan_arb_enable_seq
  import chan_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rst_done,
  input  logic tick,
  input  logic last_poll,
  output logic eng_en,
  output logic eng_rst,
  output logic done,
  output logic fail,
  output logic timer_run,
  output logic timer_restart
);
  seq_e state_q;

  assign timer_run     = (state_q != SQ_IDLE);
  assign timer_restart = (state_q == SQ_RST_ON) && tick && rst_done;
  assign done          = (state_q == SQ_RST_OFF) && tick && !rst_done;
  assign fail          = tick && last_poll &&
                         (((state_q == SQ_RST_ON) && !rst_done) ||
                          ((state_q == SQ_RST_OFF) && rst_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      eng_en  <= 1'b0;
      eng_rst <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          eng_en  <= 1'b1;
          eng_rst <= 1'b1;
          state_q <= SQ_RST_ON;
        end
        SQ_RST_ON: begin
          if (timer_restart) begin
            eng_rst <= 1'b0;
            state_q <= SQ_RST_OFF;
          end else if (fail) begin
            eng_en  <= 1'b0;
            eng_rst <= 1'b0;
            state_q <= SQ_IDLE;
          end
        end
        SQ_RST_OFF: begin
          if (done) begin
            state_q <= SQ_IDLE;
          end else if (fail) begin
            eng_en  <= 1'b0;
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assert_rst_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> eng_en);

  // Reset is released with the engine still enabled only after reset-done was seen high.
  assert_rst_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eng_rst) && eng_en) |-> $past(rst_done));

  assert_done_fail_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

// File: rtl/chan_arb_owner_track.sv
module chan_arb_owner_track
  import chan_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   host_take,
  input  logic   host_rel,
  input  logic   mcu_req,
  input  logic   mcu_rel,
  output owner_e owner
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= OWN_NONE;
    end else begin
      case (owner)
        OWN_NONE: begin
          if (mcu_req)        owner <= OWN_MCU;
          else if (host_take) owner <= OWN_HOST;
        end
        OWN_HOST: if (host_rel) owner <= OWN_NONE;
        OWN_MCU:  if (mcu_rel)  owner <= OWN_NONE;
        default:  owner <= OWN_NONE;
      endcase
    end
  end

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd3);

  assert_mcu_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_MCU && !mcu_rel) |=> owner == OWN_MCU);

  assert_host_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_HOST && host_rel) |=> owner == OWN_NONE);

  assert_mcu_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && mcu_req) |=> owner == OWN_MCU);

endmodule

// File: rtl/chan_owner_arbiter.sv
module chan_owner_arbiter
  import chan_arb_pkg::*;
#(
  parameter int POLL_CYCLES = 100,
  parameter int POLL_LIMIT  = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       host_done,
  input  logic       mcu_req,
  input  logic       mcu_done,
  input  logic       eng_rst_done,
  output logic       eng_en,
  output logic       eng_rst,
  output logic [1:0] owner_status,
  output logic       host_grant,
  output logic       host_refuse,
  output logic       timeout_err
);
  localparam int PHASE_CYCLES = phase_window(POLL_CYCLES, POLL_LIMIT);

  host_e  hstate_q;
  owner_e owner;
  logic   tick, last_poll, timer_run, timer_restart;
  logic   seq_start, seq_done, seq_fail;
  logic   host_take;

  assign seq_start = (hstate_q == HS_IDLE) && host_req &&
                     (owner == OWN_NONE) && !eng_en;
  assign host_take = (hstate_q == HS_CLAIM) && host_may_claim(owner, mcu_req);
  assign owner_status = owner;

  chan_arb_poll_timer #(
    .POLL_CYCLES(POLL_CYCLES),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (timer_run),
    .restart  (timer_restart),
    .tick     (tick),
    .last_poll(last_poll)
  );

  chan_arb_enable_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (seq_start),
    .rst_done     (eng_rst_done),
    .tick         (tick),
    .last_poll    (last_poll),
    .eng_en       (eng_en),
    .eng_rst      (eng_rst),
    .done         (seq_done),
    .fail         (seq_fail),
    .timer_run    (timer_run),
    .timer_restart(timer_restart)
  );

  chan_arb_owner_track u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_take(host_take),
    .host_rel (host_done),
    .mcu_req  (mcu_req),
    .mcu_rel  (mcu_done),
    .owner    (owner)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hstate_q    <= HS_IDLE;
      host_grant  <= 1'b0;
      host_refuse <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      host_grant  <= 1'b0;
      host_refuse <= 1'b0;
      case (hstate_q)
        HS_IDLE: if (host_req) begin
          if (owner == OWN_MCU) begin
            host_refuse <= 1'b1;
          end else if (owner == OWN_HOST) begin
            host_grant <= !host_done;
          end else if (!eng_en) begin
            timeout_err <= 1'b0;
            hstate_q    <= HS_ENABLE;
          end else begin
            timeout_err <= 1'b0;
            hstate_q    <= HS_CLAIM;
          end
        end
        HS_ENABLE: begin
          if (seq_done) begin
            hstate_q <= HS_CLAIM;
          end else if (seq_fail) begin
            timeout_err <= 1'b1;
            hstate_q    <= HS_IDLE;
          end
        end
        HS_CLAIM: begin
          host_grant  <= host_take;
          host_refuse <= !host_take;
          hstate_q    <= HS_IDLE;
        end
        default: hstate_q <= HS_IDLE;
      endcase
    end
  end

  // Elaboration-time sanity on the derived phase window.
  initial begin
    assert_window_positive_R5: assert (PHASE_CYCLES > 0);
  end

  assert_grant_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> owner == OWN_HOST);

  assert_grant_refuse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_grant && host_refuse));

  assert_timeout_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!host_grant && !eng_en && !eng_rst));

  assert_grant_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |=> !host_grant || $past(host_req));

endmodule

// File: tb/chan_owner_arbiter_test.sv
module chan_owner_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC = 2;
  localparam int PL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_done = 1'b0, mcu_req = 1'b0, mcu_done = 1'b0;
  logic eng_rst_done;
  logic eng_en, eng_rst, host_grant, host_refuse, timeout_err;
  logic [1:0] owner_status;

  int checks = 0;
  int failures = 0;
  int rd_mode = 0;   // 0 follow reset, 1 stuck low, 2 stuck high

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_owner_arbiter #(.POLL_CYCLES(PC), .POLL_LIMIT(PL)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_done(host_done),
    .mcu_req(mcu_req), .mcu_done(mcu_done), .eng_rst_done(eng_rst_done),
    .eng_en(eng_en), .eng_rst(eng_rst), .owner_status(owner_status),
    .host_grant(host_grant), .host_refuse(host_refuse), .timeout_err(timeout_err)
  );

  // Engine feedback model.
  always_ff @(posedge clk) begin
    if (rd_mode == 1)      eng_rst_done <= 1'b0;
    else if (rd_mode == 2) eng_rst_done <= 1'b1;
    else                   eng_rst_done <= eng_rst;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick_n(2);
    rst_n = 1'b1;
  endtask

  // Pulse host_req, then report the number of edges after the request edge
  // until an outcome (kind 1 grant, 2 refuse, 3 timeout) is visible.
  task automatic host_try(output int n, output int kind, output int en0, output int rst0);
    n = -1; kind = 0;
    @(negedge clk);
    host_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    en0 = eng_en; rst0 = eng_rst;
    for (int k = 0; k < 60; k++) begin
      if (host_grant)       begin n = k; kind = 1; break; end
      else if (host_refuse) begin n = k; kind = 2; break; end
      else if (timeout_err) begin n = k; kind = 3; break; end
      tick_n(1);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, kind, en0, rst0;
    do_reset();
    // R1 reset state
    chk("R1", owner_status, 0, "status after reset");
    chk("R1", eng_en, 0, "eng_en after reset");
    chk("R1", eng_rst, 0, "eng_rst after reset");

    // R3/R4/R6 full handshake with following feedback
    rd_mode = 0;
    host_try(n, kind, en0, rst0);
    chk("R3", en0 & rst0, 1, "enable and reset together");
    chk("R4", n, 2*PC+1, "grant cycle after handshake");
    chk("R6", kind, 1, "outcome is grant");
    chk("R1", owner_status, 1, "status host");

    // R9 re-request while owning
    host_try(n, kind, en0, rst0);
    chk("R9", n, 0, "re-grant cycle");
    chk("R9", kind, 1, "re-grant outcome");
    chk("R9", owner_status, 1, "status stays host");

    // R8 microcontroller waits while host owns
    @(negedge clk); mcu_req = 1'b1;
    tick_n(3);
    chk("R8", owner_status, 1, "mcu waits on host");
    pulse(host_done);
    chk("R7", owner_status, 0, "host release frees");
    tick_n(1);
    chk("R8", owner_status, 2, "mcu takes free channel");

    // R2 refused while microcontroller owns
    host_try(n, kind, en0, rst0);
    chk("R2", n, 0, "refuse cycle");
    chk("R2", kind, 2, "refuse outcome");
    chk("R2", owner_status, 2, "status unchanged");
    chk("R2", eng_rst, 0, "no sequence started");

    // R7 release from non-owner ignored
    pulse(host_done);
    tick_n(1);
    chk("R7", owner_status, 2, "host release ignored");
    @(negedge clk); mcu_req = 1'b0; mcu_done = 1'b1;
    @(negedge clk); mcu_done = 1'b0;
    chk("R7", owner_status, 0, "mcu release frees");

    // R8 simultaneous contention, engine already enabled
    @(negedge clk);
    host_req = 1'b1; mcu_req = 1'b1;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0;
    tick_n(1);
    chk("R8", host_refuse, 1, "host refused on contention");
    chk("R8", owner_status, 2, "mcu wins contention");
    @(negedge clk); mcu_req = 1'b0; mcu_done = 1'b1;
    @(negedge clk); mcu_done = 1'b0;

    // R6 enabled engine: claim one cycle after request
    host_try(n, kind, en0, rst0);
    chk("R6", n, 1, "fast grant cycle");
    chk("R6", kind, 1, "fast grant outcome");
    pulse(host_done);

    // R5 first-phase timeout
    do_reset();
    rd_mode = 1;
    host_try(n, kind, en0, rst0);
    chk("R5", n, PC*PL, "phase-one timeout cycle");
    chk("R5", kind, 3, "phase-one timeout outcome");
    chk("R5", eng_en, 0, "enable dropped");
    chk("R5", owner_status, 0, "no ownership");

    // R5 second-phase timeout
    rd_mode = 2;
    tick_n(2);
    host_try(n, kind, en0, rst0);
    chk("R5", n, PC*(PL+1), "phase-two timeout cycle");
    chk("R5", kind, 3, "phase-two timeout outcome");
    chk("R5", eng_en | eng_rst, 0, "enable and reset dropped");

    // R5 retry succeeds and clears the flag
    rd_mode = 0;
    tick_n(3);
    host_try(n, kind, en0, rst0);
    chk("R5", kind, 1, "retry grants");
    chk("R5", timeout_err, 0, "flag cleared");
    chk("R4", n, 2*PC+1, "retry grant cycle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule